// File: doc/BRIEF.md
# Secure Life Cycle State Controller

This block keeps track of the life cycle phase of a secure authentication device and decides, command by command, whether the command processor may act on a request. There are four phases, shipping, personalization, operation and destruction, and each command carries a class that names the one phase in which it is allowed. A dedicated phase-change opcode moves the device to the next phase and never back. The verdict comes out as a one-cycle accept or reject pulse on the cycle after the request.

A tamper input, raised by probing or physical-attack detectors, overrides everything else. It forces the destruction phase at once and raises a wipe request toward the memory. That request stays high until the memory reports the wipe as finished. In the destruction phase the block says nothing at all: no accept and no reject, for any command.

The phase is held in a model of nonvolatile storage. The same storage also holds the flag for an unfinished wipe. Reset does not clear either of them. On reset the working phase register is reloaded from the stored value. A load port writes the stored value directly, as a programming or power-up path, and the working phase picks it up at the next reset.

Top module: `lifecycle_guard`

## Requirements
- R1: Phase codes are 0 shipping, 1 personalization, 2 operation and 3 destruction. While `rst` is high at a clock edge, `phase` is reloaded from the stored phase, so a reset leaves an already committed phase unchanged, destruction included.
- R2: A request whose `cmd_op` is not `CHANGE_OP` and that arrives outside destruction is accepted if `cmd_class` equals `phase`, and rejected otherwise.
- R3: A request with `cmd_op == CHANGE_OP` is accepted only if `cmd_class` equals `phase + 1`. When it is accepted, `phase` takes that value at the same edge that raises `cmd_accept`. A backward, same or skipping target is rejected and leaves `phase` unchanged.
- R4: `tamper` high at an edge with `rst` low sets `phase` to 3 and raises `wipe_req` after that edge. A command presented in the same cycle gets neither an accept nor a reject.
- R5: `wipe_req` stays high until `wipe_done` is sampled high, and falls after that edge unless `tamper` is high in the same cycle. `wipe_done` has no effect when no wipe is pending.
- R6: While `phase` is 3, no command produces `cmd_accept` or `cmd_reject`.
- R7: A pending wipe survives reset: `wipe_req` is not cleared by `rst`.
- R8: `nv_load` writes `nv_load_phase` into storage and clears a pending wipe. `phase` keeps its value until the next reset, which loads the new stored value. `tamper` takes priority over `nv_load`.
- R9: Each verdict is a single-cycle pulse issued exactly one cycle after `cmd_valid`. Accept and reject are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the phase from storage |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | OP_W | Command opcode; `CHANGE_OP` selects a phase change |
| cmd_class | input | 2 | Phase the command belongs to, or the target phase for a change |
| cmd_accept | output | 1 | One-cycle pulse: command allowed |
| cmd_reject | output | 1 | One-cycle pulse: command refused |
| tamper | input | 1 | Attack detected |
| wipe_req | output | 1 | Memory erase request, held until done |
| wipe_done | input | 1 | Memory erase finished |
| nv_load | input | 1 | Write port of the stored phase |
| nv_load_phase | input | 2 | Value written by `nv_load` |
| phase | output | 2 | Current life cycle phase |

## Verification
Every result of this block is due one edge after its cause. An accept or reject pulse, a phase change, the jump to destruction and the rise or fall of the wipe request all appear right after the edge that samples the request, tamper or done input. The one exception is a stored-value load, which shows on `phase` only after the following reset edge. The bench drives inputs 2 ns after a rising edge and compares every output against its own model 2 ns after the next rising edge. Each expectation is therefore checked in the one cycle where it must hold, and an early or late response is caught. Directed sequences cover backward, same and skipping changes, a tamper arriving together with a command, and reset while a wipe is pending. Seeded random traffic covers the rest.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_SHIP = 2'b00,
        PH_PERS = 2'b01,
        PH_OPER = 2'b10,
        PH_DEST = 2'b11
    } phase_e;

    // Decoded request from the command processor
    typedef struct packed {
        logic   valid;
        logic   is_change;
        phase_e cls;
    } cmd_t;

    // Combinational verdict for the current cycle
    typedef struct packed {
        logic   accept;
        logic   reject;
        logic   commit;
        phase_e target;
    } verdict_t;

    function automatic logic is_terminal(phase_e p);
        return p == PH_DEST;
    endfunction

    // Only meaningful when p is not terminal
    function automatic phase_e successor(phase_e p);
        return phase_e'(p + 2'd1);
    endfunction

endpackage

// File: rtl/lcg_decode.sv
module lcg_decode
    import lcg_pkg::*;
#(
    parameter int              OP_W      = 8,
    parameter logic [OP_W-1:0] CHANGE_OP = 8'h5A
) (
    input  logic               valid_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic [PHASE_W-1:0] class_i,
    output cmd_t               cmd_o
);

    always_comb begin
        cmd_o.valid     = valid_i;
        cmd_o.is_change = (op_i == CHANGE_OP);
        cmd_o.cls       = phase_e'(class_i);
    end

endmodule

// File: rtl/lcg_gate.sv
module lcg_gate
    import lcg_pkg::*;
(
    input  cmd_t     cmd_i,
    input  phase_e   cur_i,
    input  logic     tamper_i,
    output verdict_t verdict_o
);

    logic   silent;
    logic   allowed;
    phase_e nxt;

    always_comb begin
        nxt     = successor(cur_i);
        silent  = tamper_i || is_terminal(cur_i) || !cmd_i.valid;
        if (cmd_i.is_change) begin
            allowed = (cmd_i.cls == nxt);
        end else begin
            allowed = (cmd_i.cls == cur_i);
        end
        verdict_o.accept = !silent && allowed;
        verdict_o.reject = !silent && !allowed;
        verdict_o.commit = !silent && allowed && cmd_i.is_change;
        verdict_o.target = nxt;
    end

endmodule

// File: rtl/lcg_nv_store.sv
module lcg_nv_store
    import lcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tamper_i,
    input  logic               load_i,
    input  logic [PHASE_W-1:0] load_phase_i,
    input  logic               wipe_done_i,
    input  logic               commit_i,
    input  phase_e             commit_phase_i,
    output phase_e             stored_o,
    output logic               wipe_pend_o
);

    // Nonvolatile model: deliberately no reset term
    phase_e stored_q;
    logic   pend_q;

    always_ff @(posedge clk) begin
        if (!rst && tamper_i) begin
            stored_q <= PH_DEST;
            pend_q   <= 1'b1;
        end else if (load_i) begin
            stored_q <= phase_e'(load_phase_i);
            pend_q   <= 1'b0;
        end else if (!rst) begin
            if (wipe_done_i) begin
                pend_q <= 1'b0;
            end
            if (commit_i) begin
                stored_q <= commit_phase_i;
            end
        end
    end

    assign stored_o    = stored_q;
    assign wipe_pend_o = pend_q;

endmodule

// File: rtl/lifecycle_guard.sv
module lifecycle_guard
    import lcg_pkg::*;
#(
    parameter int              OP_W      = 8,
    parameter logic [OP_W-1:0] CHANGE_OP = 8'h5A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [OP_W-1:0]    cmd_op,
    input  logic [PHASE_W-1:0] cmd_class,
    output logic               cmd_accept,
    output logic               cmd_reject,
    input  logic               tamper,
    output logic               wipe_req,
    input  logic               wipe_done,
    input  logic               nv_load,
    input  logic [PHASE_W-1:0] nv_load_phase,
    output logic [PHASE_W-1:0] phase
);

    cmd_t     cmd;
    verdict_t verdict;
    phase_e   stored;
    phase_e   phase_q;
    logic     acc_q;
    logic     rej_q;

    lcg_decode #(
        .OP_W      (OP_W),
        .CHANGE_OP (CHANGE_OP)
    ) u_decode (
        .valid_i (cmd_valid),
        .op_i    (cmd_op),
        .class_i (cmd_class),
        .cmd_o   (cmd)
    );

    lcg_gate u_gate (
        .cmd_i     (cmd),
        .cur_i     (phase_q),
        .tamper_i  (tamper),
        .verdict_o (verdict)
    );

    lcg_nv_store u_store (
        .clk            (clk),
        .rst            (rst),
        .tamper_i       (tamper),
        .load_i         (nv_load),
        .load_phase_i   (nv_load_phase),
        .wipe_done_i    (wipe_done),
        .commit_i       (verdict.commit),
        .commit_phase_i (verdict.target),
        .stored_o       (stored),
        .wipe_pend_o    (wipe_req)
    );

    // Working phase: reloaded from storage on reset
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= stored;
            acc_q   <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            acc_q <= verdict.accept;
            rej_q <= verdict.reject;
            if (tamper) begin
                phase_q <= PH_DEST;
            end else if (verdict.commit) begin
                phase_q <= verdict.target;
            end
        end
    end

    assign cmd_accept = acc_q;
    assign cmd_reject = rej_q;
    assign phase      = phase_q;

endmodule

// File: rtl/lifecycle_guard_chk.sv
module lifecycle_guard_chk #(
    parameter int OP_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic [1:0]      cmd_class,
    input logic            cmd_accept,
    input logic            cmd_reject,
    input logic            tamper,
    input logic            wipe_req,
    input logic            wipe_done,
    input logic            nv_load,
    input logic [1:0]      nv_load_phase,
    input logic [1:0]      phase
);

    // R9
    verdict_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_reject));

    // R9
    verdict_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_accept || cmd_reject) |-> $past(cmd_valid));

    // R3
    phase_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && phase != $past(phase)) |->
            (phase == $past(phase) + 2'd1 || phase == 2'd3));

    // R4
    tamper_destroys_chk: assert property (@(posedge clk) disable iff (rst)
        tamper |=> (phase == 2'd3 && wipe_req && !cmd_accept && !cmd_reject));

    // R5
    wipe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wipe_req && !wipe_done && !nv_load) |=> wipe_req);

    // R5
    wipe_release_chk: assert property (@(posedge clk) disable iff (rst)
        (wipe_req && wipe_done && !tamper) |=> !wipe_req);

    // R6
    dest_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd3) |=> (!cmd_accept && !cmd_reject));

endmodule

bind lifecycle_guard lifecycle_guard_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/lifecycle_guard_tb.sv
module lifecycle_guard_tb;

    localparam int         OP_W = 8;
    localparam logic [7:0] CHG  = 8'h5A;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [7:0] cmd_op;
    logic [1:0] cmd_class;
    logic       cmd_accept, cmd_reject;
    logic       tamper, wipe_req, wipe_done;
    logic       nv_load;
    logic [1:0] nv_load_phase;
    logic [1:0] phase;

    int checks   = 0;
    int failures = 0;
    bit track    = 0;

    // Reference state
    logic [1:0] m_ph, m_nv;
    bit         m_pend, m_acc, m_rej;

    always #4 clk = ~clk;

    lifecycle_guard #(.OP_W(OP_W), .CHANGE_OP(CHG)) u_dut (
        .clk, .rst, .cmd_valid, .cmd_op, .cmd_class, .cmd_accept, .cmd_reject,
        .tamper, .wipe_req, .wipe_done, .nv_load, .nv_load_phase, .phase
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit verdict_ok(logic [1:0] ph, logic [7:0] op, logic [1:0] cls);
        if (op == CHG) return (ph != 2'd3) && (cls == ph + 2'd1);
        return cls == ph;
    endfunction

    // Advance the reference by one edge using the inputs now applied
    task automatic model_step();
        logic [1:0] ph = m_ph, nv = m_nv;
        bit pend = m_pend, acc = 0, rej = 0, ok;
        ok = verdict_ok(m_ph, cmd_op, cmd_class);
        if (rst) begin
            ph = m_nv;
            if (nv_load) begin nv = nv_load_phase; pend = 0; end
        end else if (tamper) begin
            ph = 2'd3; nv = 2'd3; pend = 1;
        end else begin
            if (cmd_valid && m_ph != 2'd3) begin
                acc = ok; rej = !ok;
                if (ok && cmd_op == CHG) begin ph = m_ph + 2'd1; nv = ph; end
            end
            if (nv_load) begin nv = nv_load_phase; pend = 0; end
            else if (wipe_done) pend = 0;
        end
        m_ph = ph; m_nv = nv; m_pend = pend; m_acc = acc; m_rej = rej;
    endtask

    // One clock: inputs already set; outputs compared 2 ns after the edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        #2;
        if (track) begin
            chk("R1/R3 phase", phase, m_ph);
            chk("R2/R9 accept", cmd_accept, m_acc);
            chk("R2/R9 reject", cmd_reject, m_rej);
            chk("R5 wipe_req", wipe_req, m_pend);
        end
    endtask

    task automatic idle();
        cmd_valid = 0; cmd_op = 0; cmd_class = 0; tamper = 0;
        wipe_done = 0; nv_load = 0; nv_load_phase = 0; rst = 0;
    endtask

    task automatic cmd(input logic [7:0] op, input logic [1:0] cls);
        cmd_valid = 1; cmd_op = op; cmd_class = cls;
        cyc();
        cmd_valid = 0;
    endtask

    task automatic do_reset();
        rst = 1; cyc(); rst = 0;
    endtask

    task automatic load_and_reset(input logic [1:0] p);
        rst = 1; nv_load = 1; nv_load_phase = p; cyc();
        nv_load = 0; cyc(); rst = 0;
    endtask

    initial begin
        idle();
        m_ph = 0; m_nv = 0; m_pend = 0; m_acc = 0; m_rej = 0;
        #2;
        load_and_reset(2'd0);
        track = 1;
        cyc();
        // R1 reset state
        chk("R1 reset phase shipping", phase, 0);
        chk("R5 no wipe after load", wipe_req, 0);

        // R2 class gating in shipping
        cmd(8'h11, 2'd0); chk("R2 own-class accept", cmd_accept, 1);
        cyc();            chk("R9 pulse one cycle", cmd_accept, 0);
        cmd(8'h11, 2'd1); chk("R2 foreign-class reject", cmd_reject, 1);
        // R3 change rules
        cmd(CHG, 2'd2);   chk("R3 skip rejected", cmd_reject, 1);
        chk("R3 skip keeps phase", phase, 0);
        cmd(CHG, 2'd0);   chk("R3 same rejected", cmd_reject, 1);
        cmd(CHG, 2'd1);   chk("R3 step accepted", cmd_accept, 1);
        chk("R3 phase advanced with pulse", phase, 1);
        cmd(CHG, 2'd0);   chk("R3 backward rejected", cmd_reject, 1);
        chk("R3 backward keeps phase", phase, 1);
        cmd(CHG, 2'd2);   chk("R3 to operation", phase, 2);
        // R1 reset keeps committed phase
        do_reset();       chk("R1 reset keeps operation", phase, 2);
        // R8 load visible only after reset
        nv_load = 1; nv_load_phase = 2'd1; cyc(); nv_load = 0;
        chk("R8 load not yet visible", phase, 2);
        do_reset();       chk("R8 loaded phase after reset", phase, 1);
        // R4 tamper beats a same-cycle command
        tamper = 1; cmd_valid = 1; cmd_op = 8'h22; cmd_class = 2'd1; cyc();
        tamper = 0; cmd_valid = 0;
        chk("R4 destruction", phase, 3);
        chk("R4 wipe raised", wipe_req, 1);
        chk("R4 no accept", cmd_accept, 0);
        chk("R4 no reject", cmd_reject, 0);
        cyc(); cyc();     chk("R5 wipe held", wipe_req, 1);
        // R7 pending wipe survives reset; R1 destruction survives reset
        do_reset();       chk("R7 wipe after reset", wipe_req, 1);
        chk("R1 destruction after reset", phase, 3);
        // R6 silence
        cmd(8'h33, 2'd3); chk("R6 no accept", cmd_accept, 0);
        chk("R6 no reject", cmd_reject, 0);
        cmd(CHG, 2'd0);   chk("R6 change silent", cmd_reject, 0);
        // R5 release
        wipe_done = 1; cyc(); wipe_done = 0;
        chk("R5 wipe released", wipe_req, 0);
        wipe_done = 1; cyc(); wipe_done = 0;
        chk("R5 stray done ignored", wipe_req, 0);
        chk("R6 still destruction", phase, 3);

        // Seeded random traffic
        void'($urandom(32'h1F2E3D4C));
        load_and_reset(2'd0);
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom % 1000);
            cmd_valid = ($urandom % 10) < 6;
            cmd_op    = (($urandom % 10) < 4) ? CHG : 8'($urandom);
            if (cmd_op == CHG && ($urandom % 2) == 1) cmd_op = CHG ^ 8'h01;
            cmd_class = 2'($urandom);
            tamper    = (r < 4);
            wipe_done = ($urandom % 6) == 0;
            nv_load   = (r >= 990);
            nv_load_phase = 2'($urandom % 3);
            rst       = (r >= 975 && r < 995);
            cyc();
        end
        idle();
        cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule